// File: doc/BRIEF.md
# Translation Lookaside Buffer with Hardware Page-Table Walker

This block turns processor virtual addresses into physical addresses. The upper bits of each address name a virtual page and the lower bits name a byte inside it. The page number is compared against every entry of a small fully associative buffer at once. When an entry matches, the block answers in the same cycle. When none matches, a walker reads one page-table word from main memory, installs it in the buffer, and then completes the held request. If the page is not resident, the walker returns a page fault instead.

Every entry also carries two more bits. A writable bit makes the block refuse stores to read-only pages. A modified bit makes the block signal the first store that lands on a clean page, so software knows the page must go back to disk when it is evicted. The base register of the page table can be loaded only from supervisor state. A successful load empties the buffer, so no translation from the previous address space remains. Software can also drop one entry by page number.

Top module: `tlb_walker`

## Requirements
- R1: The physical address is the 20-bit frame number of the matching entry followed by the 12 low bits of the virtual address, which pass through unchanged.
- R2: A request whose page number matches a valid entry gets `req_ready` in the same cycle with no memory read. At most one entry ever matches a page number.
- R3: On a miss the block issues exactly one memory read at word address base + page number and holds that address until `mem_req_ready`. It keeps `req_ready` low throughout the walk. With a memory that answers the cycle after acceptance, a resident page completes 4 cycles after the request is first presented.
- R4: A page-table word has the frame in bits 31:12, the resident flag in bit 0, the modified flag in bit 1 and the writable flag in bit 2. If bit 0 is clear, the request completes 3 cycles after presentation with `rsp_page_fault` high, and nothing is installed, so a retry walks again.
- R5: A completed store to a writable page whose modified flag is clear raises `rsp_mark_dirty` and sets the flag. Later stores to that page do not raise it. An entry loaded with bit 1 already set never raises it.
- R6: A store to a page whose writable flag is clear completes with `rsp_prot_fault` high and without `rsp_mark_dirty`. Loads from that page translate normally.
- R7: `inv_en` with `inv_vpn` drops only the entry for that page. The next access to that page walks again, and other pages still hit.
- R8: A base write with `supervisor` low raises `priv_err` in that cycle and changes neither the base nor the buffer.
- R9: A base write with `supervisor` high loads the base and empties every entry in the same edge. Later walks use the new base.
- R10: On refill, the lowest-numbered empty entry is used first. With all entries full, a binary-tree pseudo-LRU picks the victim, and every hit or fill points the tree away from the entry it touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request, held until `req_ready` |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Request is a store |
| req_ready | output | 1 | Translation completes this cycle |
| rsp_paddr | output | 32 | Physical address (valid without a fault) |
| rsp_page_fault | output | 1 | Page not resident |
| rsp_prot_fault | output | 1 | Store to a read-only page |
| rsp_mark_dirty | output | 1 | First store to a clean page |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Word address of the page-table word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page-table word |
| base_wr | input | 1 | Write the page-table base register |
| base_wdata | input | 32 | New base value |
| supervisor | input | 1 | Processor is in supervisor state |
| priv_err | output | 1 | Base write refused in user state |
| inv_en | input | 1 | Drop one entry |
| inv_vpn | input | 20 | Page number to drop |

## Verification
A stale or duplicated tag shows up at once. An access that should walk completes in zero cycles, or the wrong frame appears on `rsp_paddr` in the same cycle as `req_ready`. A wrong victim choice or a lost invalidate stays hidden until the evicted or dropped page is accessed again. The checks therefore count memory reads per request and compare the completion latency (0, 3 or 4 cycles). A corrupted modified or writable flag appears only on the next store to that page, through `rsp_mark_dirty` or `rsp_prot_fault`. A wrong base shows up on the next walk's `mem_req_addr`.

// File: rtl/tlb_walker.sv
module tlb_walker #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  output logic              req_ready,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic              rsp_page_fault,
  output logic              rsp_prot_fault,
  output logic              rsp_mark_dirty,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [VA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [VA_W-1:0]   mem_rsp_data,
  input  logic              base_wr,
  input  logic [VA_W-1:0]   base_wdata,
  input  logic              supervisor,
  output logic              priv_err,
  input  logic              inv_en,
  input  logic [VA_W-OFF_W-1:0] inv_vpn
);
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int TREE_N = ENTRIES - 1;
  localparam int RES_B  = 0;
  localparam int MOD_B  = 1;
  localparam int WR_B   = 2;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_FILL, S_FAULT} state_t;

  state_t             state_q;
  logic [VPN_W-1:0]   tag_q   [ENTRIES];
  logic [VPN_W-1:0]   frame_q [ENTRIES];
  logic [ENTRIES-1:0] val_q, mod_q, wr_q;
  logic [TREE_N-1:0]  tree_q;
  logic [VA_W-1:0]    base_q;
  logic [VPN_W-1:0]   walk_vpn_q, pte_frame_q;
  logic               pte_mod_q, pte_wr_q;

  logic [VPN_W-1:0]   vpn;
  logic [ENTRIES-1:0] hit_vec;
  logic               hit, hit_w, hit_m, idle, take, flush;
  logic [IDX_W-1:0]   hit_idx, victim;
  logic [VPN_W-1:0]   hit_frame;

  assign vpn = req_vaddr[VA_W-1:OFF_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = val_q[i] && (tag_q[i] == vpn);
  end

  function automatic logic [TREE_N-1:0] touch(input logic [TREE_N-1:0] t,
                                              input logic [IDX_W-1:0] idx);
    logic [IDX_W-1:0] n;
    n = '0;
    for (int l = IDX_W - 1; l >= 0; l--) begin
      t[n] = ~idx[l];
      n = (n << 1) + IDX_W'(1) + IDX_W'(idx[l]);
    end
    return t;
  endfunction

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  always_comb begin
    logic [IDX_W-1:0] n;
    victim = '0;
    n = '0;
    if (&val_q) begin
      for (int l = IDX_W - 1; l >= 0; l--) begin
        victim[l] = tree_q[n];
        n = (n << 1) + IDX_W'(1) + IDX_W'(tree_q[n]);
      end
    end else begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!val_q[i]) victim = IDX_W'(i);
    end
  end

  assign hit       = |hit_vec;
  assign hit_frame = frame_q[hit_idx];
  assign hit_w     = wr_q[hit_idx];
  assign hit_m     = mod_q[hit_idx];
  assign idle      = (state_q == S_IDLE);
  assign take      = idle && req_valid && hit;
  assign flush     = base_wr && supervisor;

  assign req_ready      = (idle && hit) || (state_q == S_FAULT);
  assign rsp_paddr      = {hit_frame, req_vaddr[OFF_W-1:0]};
  assign rsp_page_fault = (state_q == S_FAULT);
  assign rsp_prot_fault = idle && hit && req_write && !hit_w;
  assign rsp_mark_dirty = idle && hit && req_write && hit_w && !hit_m;
  assign mem_req_valid  = (state_q == S_REQ);
  assign mem_req_addr   = base_q + VA_W'(walk_vpn_q);
  assign priv_err       = base_wr && !supervisor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      walk_vpn_q  <= '0;
      pte_frame_q <= '0;
      pte_mod_q   <= 1'b0;
      pte_wr_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE:  if (req_valid && !hit) begin
                   walk_vpn_q <= vpn;
                   state_q    <= S_REQ;
                 end
        S_REQ:   if (mem_req_ready) state_q <= S_WAIT;
        S_WAIT:  if (mem_rsp_valid) begin
                   pte_frame_q <= mem_rsp_data[VA_W-1:OFF_W];
                   pte_mod_q   <= mem_rsp_data[MOD_B];
                   pte_wr_q    <= mem_rsp_data[WR_B];
                   state_q     <= mem_rsp_data[RES_B] ? S_FILL : S_FAULT;
                 end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      mod_q  <= '0;
      tree_q <= '0;
      base_q <= '0;
    end else begin
      if (state_q == S_FILL) begin
        val_q[victim] <= 1'b1;
        mod_q[victim] <= pte_mod_q;
        tree_q        <= touch(tree_q, victim);
      end else if (take) begin
        tree_q <= touch(tree_q, hit_idx);
        if (rsp_mark_dirty) mod_q[hit_idx] <= 1'b1;
      end
      if (inv_en)
        for (int i = 0; i < ENTRIES; i++)
          if (tag_q[i] == inv_vpn) val_q[i] <= 1'b0;
      if (flush) begin
        val_q  <= '0;
        base_q <= base_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == S_FILL) begin
      tag_q[victim]   <= walk_vpn_q;
      frame_q[victim] <= pte_frame_q;
      wr_q[victim]    <= pte_wr_q;
    end
  end

  p_one_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_walk_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_REQ || state_q == S_WAIT || state_q == S_FILL) |-> !req_ready);

  p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_fault_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_page_fault |-> $past(mem_rsp_valid) && !$past(mem_rsp_data[RES_B]));

  p_prot_keeps_mod_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && rsp_prot_fault |=> mod_q == $past(mod_q));

  p_user_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    priv_err |=> $stable(base_q));

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr && supervisor |=> val_q == '0);
endmodule

// File: tb/tlb_walker_test.sv
module tlb_walker_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_page_fault, rsp_prot_fault, rsp_mark_dirty;
  logic [31:0] rsp_paddr;
  logic        mem_req_valid, mem_req_ready = 1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        base_wr = 0, supervisor = 0, inv_en = 0;
  logic [31:0] base_wdata = '0;
  logic [19:0] inv_vpn = '0;
  logic        priv_err;

  tlb_walker uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .req_ready(req_ready), .rsp_paddr(rsp_paddr),
    .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault),
    .rsp_mark_dirty(rsp_mark_dirty),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .base_wr(base_wr), .base_wdata(base_wdata), .supervisor(supervisor),
    .priv_err(priv_err), .inv_en(inv_en), .inv_vpn(inv_vpn)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] tb_base = '0;
  int          walks = 0;
  logic [31:0] last_walk_addr = '0;

  // Page-table contents: frame = vpn ^ 5A5A5; vpn[7:4] selects the flags
  // F: not resident, E: read-only, D: writable and already modified, else writable
  function automatic logic [31:0] pte_of(input logic [31:0] idx);
    logic [19:0] v;
    logic [2:0]  f;
    v = idx[19:0];
    case (v[7:4])
      4'hF:    f = 3'b000;
      4'hE:    f = 3'b001;
      4'hD:    f = 3'b111;
      default: f = 3'b101;
    endcase
    return {v ^ 20'h5A5A5, 9'd0, f};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      mem_rsp_data  <= pte_of(mem_req_addr - tb_base);
      if (mem_req_valid && mem_req_ready) begin
        walks          <= walks + 1;
        last_walk_addr <= mem_req_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] o_paddr;
  logic        o_pf, o_prot, o_dirty;
  int          o_walks, o_cyc;

  task automatic xlate(input logic [31:0] va, input logic wr);
    int w0;
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_valid = 1;
    w0 = walks; o_cyc = 0;
    #1;
    while (!req_ready && o_cyc < 60) begin
      @(negedge clk); #1; o_cyc++;
    end
    o_paddr = rsp_paddr; o_pf = rsp_page_fault; o_prot = rsp_prot_fault;
    o_dirty = rsp_mark_dirty; o_walks = walks - w0;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic set_base(input logic [31:0] v, input logic sup, input logic exp_err);
    @(negedge clk);
    base_wr = 1; base_wdata = v; supervisor = sup;
    #1;
    chk(priv_err == exp_err, sup ? "R9 priv_err" : "R8 priv_err", 32'(priv_err), 32'(exp_err));
    @(negedge clk);
    base_wr = 0;
    if (sup) tb_base = v;
  endtask

  task automatic expect_walk(input logic [31:0] va, input bit exp_walk, input string req);
    xlate(va, 1'b0);
    chk(o_walks == 32'(exp_walk), req, 32'(o_walks), 32'(exp_walk));
    if (exp_walk)
      chk(last_walk_addr == tb_base + {12'd0, va[31:12]}, req, last_walk_addr,
          tb_base + {12'd0, va[31:12]});
  endtask

  // {vaddr, write, exp_walk, exp_page_fault, exp_prot_fault, exp_dirty}
  localparam int NV = 10;
  localparam logic [36:0] VEC [NV] = '{
    {32'h0001_0123, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 cold miss
    {32'h0001_0FFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R1 R2 same page, top offset
    {32'h0001_0004, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R5 first store
    {32'h0001_0008, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 second store
    {32'h000E_1010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R6 load read-only
    {32'h000E_1010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R6 store read-only
    {32'h000F_2000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R4 not resident
    {32'h000F_2000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R4 nothing installed
    {32'h000D_3444, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 preset modified
    {32'hFFF0_1ABC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}   // R1 high page
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 0, "R2 reset ready", 32'(req_ready), 0);
    chk(mem_req_valid == 0, "R3 reset mem", 32'(mem_req_valid), 0);
    chk(priv_err == 0, "R8 reset priv", 32'(priv_err), 0);
    rst_n = 1;

    set_base(32'h0001_0000, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] va;
      logic wr, ew, epf, epr, edt;
      int ecyc;
      {va, wr, ew, epf, epr, edt} = VEC[i];
      xlate(va, wr);
      ecyc = epf ? 3 : (ew ? 4 : 0);
      chk(o_walks == 32'(ew), "R2 R3 walk count", 32'(o_walks), 32'(ew));
      chk(o_cyc == ecyc, "R3 R4 latency", 32'(o_cyc), 32'(ecyc));
      chk(o_pf == epf, "R4 page fault", 32'(o_pf), 32'(epf));
      chk(o_prot == epr, "R6 prot fault", 32'(o_prot), 32'(epr));
      chk(o_dirty == edt, "R5 mark dirty", 32'(o_dirty), 32'(edt));
      if (!epf)
        chk(o_paddr == {va[31:12] ^ 20'h5A5A5, va[11:0]}, "R1 paddr", o_paddr,
            {va[31:12] ^ 20'h5A5A5, va[11:0]});
      if (ew)
        chk(last_walk_addr == tb_base + {12'd0, va[31:12]}, "R3 walk addr",
            last_walk_addr, tb_base + {12'd0, va[31:12]});
    end

    // R7 single-entry invalidate
    @(negedge clk); inv_en = 1; inv_vpn = 20'h00010;
    @(negedge clk); inv_en = 0;
    expect_walk(32'h0001_0123, 1'b1, "R7 dropped page walks");
    expect_walk(32'h000E_1010, 1'b0, "R7 other page hits");

    // R3 memory stall: address held, requester stalled
    mem_req_ready = 0;
    @(negedge clk);
    req_vaddr = 32'h0007_7000; req_write = 0; req_valid = 1;
    repeat (4) begin
      @(negedge clk); #1;
    end
    chk(req_ready == 0, "R3 stalled ready", 32'(req_ready), 0);
    chk(mem_req_valid == 1, "R3 stalled mem valid", 32'(mem_req_valid), 1);
    chk(mem_req_addr == tb_base + 32'h77, "R3 stalled addr", mem_req_addr, tb_base + 32'h77);
    mem_req_ready = 1;
    begin
      int n = 0;
      while (!req_ready && n < 20) begin @(negedge clk); #1; n++; end
    end
    chk(rsp_paddr == {20'h00077 ^ 20'h5A5A5, 12'h000}, "R3 stalled result", rsp_paddr,
        {20'h00077 ^ 20'h5A5A5, 12'h000});
    @(negedge clk); req_valid = 0;

    // R8 user-state base write refused
    set_base(32'h0009_9000, 1'b0, 1'b1);
    expect_walk(32'h0007_8000, 1'b1, "R8 base unchanged");
    expect_walk(32'h000E_1010, 1'b0, "R8 no flush");

    // R9 supervisor base write flushes and retargets
    set_base(32'h0004_0000, 1'b1, 1'b0);
    expect_walk(32'h000E_1010, 1'b1, "R9 flushed, new base");
    expect_walk(32'h0001_0123, 1'b1, "R9 flushed second");

    // R10 fill order and pseudo-LRU victim
    set_base(32'h0005_0000, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++)
      expect_walk(32'h0010_0000 + (i << 12), 1'b1, "R10 fill");
    expect_walk(32'h0010_0000, 1'b0, "R10 touch entry 0");
    expect_walk(32'h0020_0000, 1'b1, "R10 replace");
    expect_walk(32'h0010_1000, 1'b0, "R10 kept 1");
    expect_walk(32'h0010_5000, 1'b0, "R10 kept 5");
    expect_walk(32'h0010_0000, 1'b0, "R10 kept 0");
    expect_walk(32'h0010_4000, 1'b1, "R10 victim 4 evicted");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule